// File: doc/BRIEF.md
# Dual-Rail Fault-Detecting Gate Array

This block evaluates a row of logic operations where every logical bit travels as a pair of complementary wires. A value of 0 is the pair `01`, a value of 1 is the pair `10`, and `00` is a fault marker. The marker passes through every gadget: once any operand is `00`, every result that depends on it is also `00`. The gadgets are built only from AND and OR terms over the input rails. Because of that, pulling any internal wire low can only remove a valid code. It can never make the other valid code, and it can never make `11`.

Each lane takes two encoded operands and a 2-bit operation code, and registers one encoded result. The lane also registers the logical bit of that result, read from its first wire. A separate encoder path turns a plain bit per lane into a registered pair. A fault hook lets the testbench pull any single internal wire of any lane to 0. This is how the detection property is exercised.

Top module: `drl_gate_array`

## Requirements
- R1: The encoder output for lane i, one clock after `plain_in[i]` is sampled, is `10` for a 1 and `01` for a 0. The first wire is the bit itself and the second wire is its inverse.
- R2: Operation code 0 (AND) gives `10` only for operands `10`,`10` and gives `01` for the other three valid combinations.
- R3: Operation code 1 (XOR) gives `10` when exactly one valid operand is `10`, and `01` when both valid operands are equal.
- R4: Operation code 2 (NOT) swaps the two wires of operand A. This turns `01` into `10` and `10` into `01`, and leaves `00` as `00`.
- R5: Operation code 3 (pass) returns operand A unchanged.
- R6: Under AND or XOR, an operand pair of `00` on either side gives a result of `00`.
- R7: `res_bit[i]` equals the first (upper) wire of the registered result pair of lane i.
- R8: With one internal wire pulled to 0 through the fault hook, the affected lane's result is either its fault-free value or `00`, and never `11`. All other lanes keep their fault-free values. Wire index = lane*12 + w, where w 0..5 are the AND gadget wires and w 6..11 are the XOR gadget wires.
- R9: While `rst_n` is low at a clock edge, every registered output (`enc_out`, `res_out`, `res_bit`) becomes 0 at that edge.
- R10: No result pair or encoder pair is ever `11` while the operands carry no `11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| plain_in | input | LANES | Plain bits to encode, one per lane |
| op_sel | input | 2*LANES | Operation code per lane (0 AND, 1 XOR, 2 NOT, 3 pass) |
| opa | input | 2*LANES | Encoded operand A per lane |
| opb | input | 2*LANES | Encoded operand B per lane |
| flt_en | input | 1 | Enables the zero-forcing fault hook |
| flt_idx | input | FIW | Global index of the internal wire to pull low |
| enc_out | output | 2*LANES | Registered encoded pairs from `plain_in` |
| res_out | output | 2*LANES | Registered encoded result per lane |
| res_bit | output | LANES | Registered decoded result bit per lane |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The gadgets are combinational, and the only register on the path is the output stage. The bench changes inputs on a falling edge, waits through one rising edge, and samples on the next falling edge. Fault injection follows the same rule: the fault index is set together with the operands, and the lane is checked one edge later. Reset is checked on the falling edge after the edge where reset was seen low.

// File: rtl/drl_pkg.sv
`timescale 1ns/1ps
// Shared types and codes for the dual-rail gate array.
// Assumes: bit [1] of a pair is the true rail, bit [0] the complement rail.
package drl_pkg;
    typedef logic [1:0] pair_t;

    localparam pair_t PAIR_ZERO = 2'b01;
    localparam pair_t PAIR_ONE  = 2'b10;
    localparam pair_t PAIR_ERR  = 2'b00;

    // Internal wires per gadget, and per lane (AND gadget then XOR gadget)
    localparam int GADGET_WIRES = 6;
    localparam int LANE_WIRES   = 2 * GADGET_WIRES;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_XOR  = 2'd1,
        OP_NOT  = 2'd2,
        OP_PASS = 2'd3
    } op_t;
endpackage

// File: rtl/drl_enc.sv
`timescale 1ns/1ps
// Encoder: converts a plain bit into a complementary pair.
// Assumes: nothing; the inverter sits only at this gadget's input side.
module drl_enc
    import drl_pkg::*;
(
    input  logic  bit_in,
    output pair_t pair_out
);
    // Fan the bit onto the true rail and invert it onto the complement rail
    always_comb begin
        pair_out = {bit_in, ~bit_in};
    end
endmodule

// File: rtl/drl_dec.sv
`timescale 1ns/1ps
// Decoder: returns the logical bit of a pair.
// Assumes: the complement rail carries no extra information here.
module drl_dec
    import drl_pkg::*;
(
    input  pair_t pair_in,
    output logic  bit_out
);
    // The true rail alone gives the value
    always_comb begin
        bit_out = pair_in[1];
    end
endmodule

// File: rtl/drl_and.sv
`timescale 1ns/1ps
// Encoded AND gadget: a monotone sum of products over the input rails.
// Assumes: inputs never carry 11. kill[w] pulls internal wire w to 0
// (wires 0..3 are product terms, 4 and 5 are the output rails).
module drl_and
    import drl_pkg::*;
(
    input  pair_t                   a,
    input  pair_t                   b,
    input  logic [GADGET_WIRES-1:0] kill,
    output pair_t                   y
);
    logic [3:0] term;

    // Product terms, one per valid input combination, each with its fault hook
    always_comb begin
        term[0] = (a[1] & b[1]) & ~kill[0];
        term[1] = (a[0] & b[1]) & ~kill[1];
        term[2] = (a[1] & b[0]) & ~kill[2];
        term[3] = (a[0] & b[0]) & ~kill[3];
    end

    // Output rails: true only for 1&1, complement for any other valid pair
    always_comb begin
        y[1] = term[0] & ~kill[4];
        y[0] = (term[1] | term[2] | term[3]) & ~kill[5];
    end

    // R10
    always_comb begin
        if (a != 2'b11 && b != 2'b11) begin
            and_no_hot_chk: assert (y != 2'b11);
        end
    end

    // R6
    always_comb begin
        if (a == PAIR_ERR || b == PAIR_ERR) begin
            and_err_prop_chk: assert (y == PAIR_ERR);
        end
    end
endmodule

// File: rtl/drl_xor.sv
`timescale 1ns/1ps
// Encoded XOR gadget: a monotone sum of products over the input rails.
// Assumes: inputs never carry 11. kill[w] pulls internal wire w to 0
// (wires 0..3 are product terms, 4 and 5 are the output rails).
module drl_xor
    import drl_pkg::*;
(
    input  pair_t                   a,
    input  pair_t                   b,
    input  logic [GADGET_WIRES-1:0] kill,
    output pair_t                   y
);
    logic [3:0] term;

    // Product terms; 0 and 1 feed the true rail, 2 and 3 the complement rail
    always_comb begin
        term[0] = (a[1] & b[0]) & ~kill[0];
        term[1] = (a[0] & b[1]) & ~kill[1];
        term[2] = (a[1] & b[1]) & ~kill[2];
        term[3] = (a[0] & b[0]) & ~kill[3];
    end

    // Output rails: true when the values differ, complement when equal
    always_comb begin
        y[1] = (term[0] | term[1]) & ~kill[4];
        y[0] = (term[2] | term[3]) & ~kill[5];
    end

    // R10
    always_comb begin
        if (a != 2'b11 && b != 2'b11) begin
            xor_no_hot_chk: assert (y != 2'b11);
        end
    end

    // R6
    always_comb begin
        if (a == PAIR_ERR || b == PAIR_ERR) begin
            xor_err_prop_chk: assert (y == PAIR_ERR);
        end
    end
endmodule

// File: rtl/drl_not.sv
`timescale 1ns/1ps
// Encoded NOT gadget: exchanges the two rails, no gates involved.
// Assumes: an error pair 00 stays 00 by construction.
module drl_not
    import drl_pkg::*;
(
    input  pair_t a,
    output pair_t y
);
    // Rail swap
    always_comb begin
        y = {a[0], a[1]};
    end
endmodule

// File: rtl/drl_lane.sv
`timescale 1ns/1ps
// One lane: runs the AND, XOR and NOT gadgets in parallel and selects
// the result named by the operation code.
// Assumes: kill carries at most the fault mask for this lane's wires.
module drl_lane
    import drl_pkg::*;
(
    input  op_t                   op,
    input  pair_t                 a,
    input  pair_t                 b,
    input  logic [LANE_WIRES-1:0] kill,
    output pair_t                 y
);
    pair_t y_and;
    pair_t y_xor;
    pair_t y_not;

    drl_and u_and (
        .a    (a),
        .b    (b),
        .kill (kill[GADGET_WIRES-1:0]),
        .y    (y_and)
    );

    drl_xor u_xor (
        .a    (a),
        .b    (b),
        .kill (kill[LANE_WIRES-1:GADGET_WIRES]),
        .y    (y_xor)
    );

    drl_not u_not (
        .a (a),
        .y (y_not)
    );

    // Result select by operation code
    always_comb begin
        unique case (op)
            OP_AND:  y = y_and;
            OP_XOR:  y = y_xor;
            OP_NOT:  y = y_not;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/drl_gate_array.sv
`timescale 1ns/1ps
// Top: LANES dual-rail lanes plus an encoder row. Results, decoded bits
// and encoder pairs are registered once. A single internal wire,
// addressed by flt_idx = lane*12 + w, can be pulled to 0 for test.
// Assumes: operands never carry 11; synchronous active-low reset.
module drl_gate_array
    import drl_pkg::*;
#(
    parameter  int LANES = 4,
    localparam int NWIRE = LANES * LANE_WIRES,
    localparam int FIW   = (NWIRE > 1) ? $clog2(NWIRE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   plain_in,
    input  logic [2*LANES-1:0] op_sel,
    input  logic [2*LANES-1:0] opa,
    input  logic [2*LANES-1:0] opb,
    input  logic               flt_en,
    input  logic [FIW-1:0]     flt_idx,
    output logic [2*LANES-1:0] enc_out,
    output logic [2*LANES-1:0] res_out,
    output logic [LANES-1:0]   res_bit
);
    logic [2*LANES-1:0] enc_d;
    logic [2*LANES-1:0] res_d;
    logic [LANES-1:0]   bit_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_WIRES-1:0] kill;

        // Decode the fault address into this lane's kill mask
        always_comb begin
            for (int w = 0; w < LANE_WIRES; w++) begin
                kill[w] = flt_en && (int'(flt_idx) == l * LANE_WIRES + w);
            end
        end

        drl_lane u_lane (
            .op   (op_t'(op_sel[2*l +: 2])),
            .a    (opa[2*l +: 2]),
            .b    (opb[2*l +: 2]),
            .kill (kill),
            .y    (res_d[2*l +: 2])
        );

        drl_enc u_enc (
            .bit_in   (plain_in[l]),
            .pair_out (enc_d[2*l +: 2])
        );

        drl_dec u_dec (
            .pair_in  (res_d[2*l +: 2]),
            .bit_out  (bit_d[l])
        );

        // R9
        rst_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (res_out[2*l +: 2] == 2'b00 && enc_out[2*l +: 2] == 2'b00
                        && !res_bit[l]));

        // R10
        res_no_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (opa[2*l +: 2] != 2'b11 && opb[2*l +: 2] != 2'b11)
            |=> res_out[2*l +: 2] != 2'b11);

        // R1
        enc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> enc_out[2*l +: 2] == {$past(plain_in[l]), ~$past(plain_in[l])});

        // R6
        err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel[2*l +: 2] <= 2'd1 && (opa[2*l +: 2] == 2'b00 || opb[2*l +: 2] == 2'b00))
            |=> res_out[2*l +: 2] == 2'b00);

        // R4
        not_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel[2*l +: 2] == 2'd2)
            |=> res_out[2*l +: 2] == {$past(opa[2*l]), $past(opa[2*l+1])});
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_out <= '0;
            res_out <= '0;
            res_bit <= '0;
        end else begin
            enc_out <= enc_d;
            res_out <= res_d;
            res_bit <= bit_d;
        end
    end
endmodule

// File: tb/drl_gate_array_tb.sv
`timescale 1ns/1ps
module drl_gate_array_tb_top;
    localparam int LANES = 4;
    localparam int FIW   = $clog2(LANES * 12);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [LANES-1:0]   plain_in = '0;
    logic [2*LANES-1:0] op_sel = '0;
    logic [2*LANES-1:0] opa = '0;
    logic [2*LANES-1:0] opb = '0;
    logic               flt_en = 1'b0;
    logic [FIW-1:0]     flt_idx = '0;
    logic [2*LANES-1:0] enc_out;
    logic [2*LANES-1:0] res_out;
    logic [LANES-1:0]   res_bit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    drl_gate_array #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .plain_in(plain_in), .op_sel(op_sel),
        .opa(opa), .opb(opb), .flt_en(flt_en), .flt_idx(flt_idx),
        .enc_out(enc_out), .res_out(res_out), .res_bit(res_bit)
    );

    // {op, a, b, expected}
    localparam logic [7:0] VEC [16] = '{
        {2'd0, 2'b01, 2'b01, 2'b01}, {2'd0, 2'b01, 2'b10, 2'b01},
        {2'd0, 2'b10, 2'b01, 2'b01}, {2'd0, 2'b10, 2'b10, 2'b10},
        {2'd1, 2'b01, 2'b01, 2'b01}, {2'd1, 2'b01, 2'b10, 2'b10},
        {2'd1, 2'b10, 2'b01, 2'b10}, {2'd1, 2'b10, 2'b10, 2'b01},
        {2'd2, 2'b01, 2'b10, 2'b10}, {2'd2, 2'b10, 2'b01, 2'b01},
        {2'd2, 2'b00, 2'b10, 2'b00}, {2'd3, 2'b10, 2'b01, 2'b10},
        {2'd0, 2'b00, 2'b10, 2'b00}, {2'd0, 2'b10, 2'b00, 2'b00},
        {2'd1, 2'b01, 2'b00, 2'b00}, {2'd1, 2'b00, 2'b10, 2'b00}
    };

    function automatic logic [1:0] golden(input logic [1:0] op, input logic [1:0] a,
                                          input logic [1:0] b);
        logic r;
        if (op == 2'd2) return {a[0], a[1]};
        if (op == 2'd3) return a;
        if (a == 2'b00 || b == 2'b00) return 2'b00;
        r = (op == 2'd0) ? (a[1] & b[1]) : (a[1] ^ b[1]);
        return r ? 2'b10 : 2'b01;
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_all(input logic [1:0] op, input logic [1:0] a, input logic [1:0] b);
        for (int l = 0; l < LANES; l++) begin
            op_sel[2*l +: 2] = op;
            opa[2*l +: 2]    = a;
            opb[2*l +: 2]    = b;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        drive_all(2'd0, 2'b10, 2'b10);
        plain_in = '1;
        repeat (3) @(negedge clk);
        // R9: reset clears everything despite live inputs
        check(res_out == '0 && enc_out == '0 && res_bit == '0, "R9",
              {res_out}, 8'h00);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R7: table walk on all lanes
        for (int v = 0; v < 16; v++) begin
            drive_all(VEC[v][7:6], VEC[v][5:4], VEC[v][3:2]);
            step();
            for (int l = 0; l < LANES; l++) begin
                check(res_out[2*l +: 2] == VEC[v][1:0], "R2/R3/R4/R5/R6 table",
                      {6'b0, res_out[2*l +: 2]}, {6'b0, VEC[v][1:0]});
                check(res_bit[l] == VEC[v][1], "R7 decode",
                      {7'b0, res_bit[l]}, {7'b0, VEC[v][1]});
            end
        end

        // R1: encoder with two patterns
        plain_in = 4'b1010;
        step();
        check(enc_out == 8'b10011001, "R1 enc", enc_out, 8'b10011001);
        plain_in = 4'b0011;
        step();
        check(enc_out == 8'b01011010, "R1 enc", enc_out, 8'b01011010);

        // Mixed ops across lanes: lane0 AND, lane1 XOR, lane2 NOT, lane3 pass
        op_sel = {2'd3, 2'd2, 2'd1, 2'd0};
        opa    = {2'b01, 2'b10, 2'b10, 2'b10};
        opb    = {2'b10, 2'b10, 2'b10, 2'b10};
        step();
        check(res_out == {2'b01, 2'b01, 2'b01, 2'b10}, "R5 mixed lanes",
              res_out, {2'b01, 2'b01, 2'b01, 2'b10});

        // R8: each single wire of lanes 0 and 1 pulled low, AND and XOR, all valid inputs
        for (int fl = 0; fl < 2; fl++) begin
            for (int w = 0; w < 12; w++) begin
                for (int op = 0; op < 2; op++) begin
                    for (int ab = 0; ab < 4; ab++) begin
                        logic [1:0] a, b, g;
                        a = ab[1] ? 2'b10 : 2'b01;
                        b = ab[0] ? 2'b10 : 2'b01;
                        g = golden(op[1:0], a, b);
                        drive_all(op[1:0], a, b);
                        flt_en  = 1'b1;
                        flt_idx = FIW'(fl * 12 + w);
                        step();
                        for (int l = 0; l < LANES; l++) begin
                            if (l == fl)
                                check((res_out[2*l +: 2] == g || res_out[2*l +: 2] == 2'b00)
                                      && res_out[2*l +: 2] != 2'b11, "R8 faulted lane",
                                      {6'b0, res_out[2*l +: 2]}, {6'b0, g});
                            else
                                check(res_out[2*l +: 2] == g, "R8 other lane",
                                      {6'b0, res_out[2*l +: 2]}, {6'b0, g});
                        end
                    end
                end
            end
        end

        // R8: fault on AND true-product wire with 1&1 turns into error pair
        drive_all(2'd0, 2'b10, 2'b10);
        flt_en  = 1'b1;
        flt_idx = FIW'(0);
        step();
        check(res_out[1:0] == 2'b00, "R8 detect", {6'b0, res_out[1:0]}, 8'h00);
        // R8: XOR output rail 4 of lane 1 pulled low, 1^0 becomes error
        drive_all(2'd1, 2'b10, 2'b01);
        flt_idx = FIW'(12 + 10);
        step();
        check(res_out[3:2] == 2'b00, "R8 detect xor", {6'b0, res_out[3:2]}, 8'h00);
        // R8: hook off, value returns
        flt_en = 1'b0;
        step();
        check(res_out[3:2] == 2'b10, "R8 release", {6'b0, res_out[3:2]}, 8'h02);

        // R10: no 11 after a run of mixed traffic
        drive_all(2'd1, 2'b00, 2'b00);
        step();
        check(res_out == '0, "R10/R6 both err", res_out, 8'h00);

        // R9: reset mid-run
        drive_all(2'd0, 2'b10, 2'b10);
        plain_in = '1;
        rst_n = 1'b0;
        step();
        check(res_out == '0 && enc_out == '0 && res_bit == '0, "R9 mid-run",
              res_out, 8'h00);
        rst_n = 1'b1;
        step();
        check(res_out == 8'b10101010, "R2 after reset", res_out, 8'b10101010);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule